// File: doc/BRIEF.md
# Immediate-Capable Integer Execute Stage

This block is the execute stage of a 32-bit load/store integer core, paired with the register file it reads and writes. On each cycle it reads two source registers, applies the operation selected on a 4-bit code, and produces a 32-bit result. That result can be written to a destination register on the next rising clock edge. The stage handles register-register arithmetic, register-immediate arithmetic, logic and signed comparisons.

The block also supports building constants. The upper-immediate operation writes a 16-bit field into the top half of a register and clears the bottom half. An OR-immediate on the same register then fills in the low half. Together, the two operations produce any 32-bit value.

Each operation picks its own extension rule for the 16-bit field. Entry zero of the register file is wired to zero. Decoding raw instruction words, memory access and branching belong to other stages.

Top module: `rix_exec_top`

## Requirements
- R1: Code 0 gives rs+rt and code 1 gives rs-rt. Both wrap modulo 2^32 and raise no trap.
- R2: Code 2 adds the sign-extended 16-bit immediate to rs.
- R3: Code 3 gives 1 when rs is less than rt as signed two's-complement values, and 0 otherwise. Bits 31:1 are always zero.
- R4: Code 4 gives 1 when rs is less than the sign-extended immediate, compared as signed values, and 0 otherwise.
- R5: Code 5 gives rs AND the zero-extended immediate. Code 6 gives rs OR the zero-extended immediate.
- R6: Code 7 places the immediate in bits 31:16 and zeros in bits 15:0. The value of rs has no effect.
- R7: Code 7 followed by code 6 on the same register leaves that register holding {upper field, lower field}.
- R8: Entry 0 always reads as zero, and writes to it are ignored.
- R9: When wr_en_i is 1, result_o is written to entry rd_addr_i on the rising clock edge. When wr_en_i is 0, no entry changes. Reads are combinational and show the value held before the edge, including in the cycle that writes the same entry.
- R10: The active-low asynchronous reset clears all 32 entries to zero.
- R11: Codes 8 to 15 give a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation code (see requirements) |
| rs_addr_i | input | 5 | First source register index |
| rt_addr_i | input | 5 | Second source register index |
| rd_addr_i | input | 5 | Destination register index |
| imm_i | input | 16 | Immediate field |
| wr_en_i | input | 1 | Write result to destination at clock edge |
| rs_data_o | output | 32 | First source register value |
| rt_data_o | output | 32 | Second source register value |
| result_o | output | 32 | Execute result |

## Verification
A write and a read of the same register can occur in the same cycle. The constant-building pair makes this overlap most often. The bench provokes it by issuing an OR-immediate whose source and destination are the register being rebuilt, straight after the upper-immediate, and also by reading the destination while it is being written. In that cycle, rs_data_o and result_o must reflect the pre-edge value. The new value must appear only on the following cycle. The reference model applies each write only after comparing that cycle's outputs.

// File: rtl/rix_pkg.sv
package rix_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADDI = 4'd2,
    OP_SLT  = 4'd3,
    OP_SLTI = 4'd4,
    OP_ANDI = 4'd5,
    OP_ORI  = 4'd6,
    OP_LUI  = 4'd7
  } op_e;
endpackage

// File: rtl/rix_imm_ext.sv
module rix_imm_ext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  rix_pkg::op_e      op_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] ext_o
);
  import rix_pkg::*;
  localparam int PAD_W = DATA_W - IMM_W;

  logic sign_sel;
  always_comb begin
    sign_sel = (op_i == OP_ADDI) || (op_i == OP_SLTI);
    ext_o    = {{PAD_W{sign_sel & imm_i[IMM_W-1]}}, imm_i};
  end
endmodule

// File: rtl/rix_alu.sv
module rix_alu #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  rix_pkg::op_e      op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_reg_i,
  input  logic [DATA_W-1:0] b_imm_i,
  input  logic [IMM_W-1:0]  imm_raw_i,
  output logic [DATA_W-1:0] res_o
);
  import rix_pkg::*;
  localparam int LOW_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] b_sel;
  logic              lt;

  always_comb begin
    b_sel = ((op_i == OP_ADD) || (op_i == OP_SUB) || (op_i == OP_SLT)) ? b_reg_i : b_imm_i;
    lt    = $signed(a_i) < $signed(b_sel);
    unique case (op_i)
      OP_ADD, OP_ADDI: res_o = a_i + b_sel;
      OP_SUB:          res_o = a_i - b_sel;
      OP_SLT, OP_SLTI: res_o = {{(DATA_W-1){1'b0}}, lt};
      OP_ANDI:         res_o = a_i & b_sel;
      OP_ORI:          res_o = a_i | b_sel;
      OP_LUI:          res_o = {imm_raw_i, {LOW_W{1'b0}}};
      default:         res_o = '0;
    endcase
  end
endmodule

// File: rtl/rix_regfile.sv
module rix_regfile #(
  parameter int DATA_W = 32,
  parameter int REG_N  = 32,
  parameter int RD_N   = 2,
  localparam int ADDR_W = $clog2(REG_N)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [RD_N-1:0][ADDR_W-1:0] raddr_i,
  output logic [RD_N-1:0][DATA_W-1:0] rdata_o,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      waddr_i,
  input  logic [DATA_W-1:0]      wdata_i
);
  logic [DATA_W-1:0] regs_q [REG_N];

  for (genvar i = 0; i < REG_N; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign regs_q[i] = '0;
    end else begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                    regs_q[i] <= '0;
        else if (we_i && (waddr_i == ADDR_W'(i)))       regs_q[i] <= wdata_i;
      end
    end
  end

  for (genvar p = 0; p < RD_N; p++) begin : g_rd
    assign rdata_o[p] = regs_q[raddr_i[p]];
  end
endmodule

// File: rtl/rix_exec_top.sv
module rix_exec_top #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int REG_N  = 32,
  localparam int ADDR_W = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [ADDR_W-1:0] rs_addr_i,
  input  logic [ADDR_W-1:0] rt_addr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              wr_en_i,
  output logic [DATA_W-1:0] rs_data_o,
  output logic [DATA_W-1:0] rt_data_o,
  output logic [DATA_W-1:0] result_o
);
  import rix_pkg::*;

  op_e                         op;
  logic [1:0][ADDR_W-1:0]      raddr;
  logic [1:0][DATA_W-1:0]      rdata;
  logic [DATA_W-1:0]           imm_ext;

  assign op       = op_e'(op_i);
  assign raddr    = {rt_addr_i, rs_addr_i};
  assign rs_data_o = rdata[0];
  assign rt_data_o = rdata[1];

  rix_regfile #(.DATA_W(DATA_W), .REG_N(REG_N), .RD_N(2)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raddr_i (raddr),
    .rdata_o (rdata),
    .we_i    (wr_en_i),
    .waddr_i (rd_addr_i),
    .wdata_i (result_o)
  );

  rix_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
    .op_i  (op),
    .imm_i (imm_i),
    .ext_o (imm_ext)
  );

  rix_alu #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_alu (
    .op_i      (op),
    .a_i       (rdata[0]),
    .b_reg_i   (rdata[1]),
    .b_imm_i   (imm_ext),
    .imm_raw_i (imm_i),
    .res_o     (result_o)
  );
endmodule

// File: rtl/rix_exec_chk.sv
module rix_exec_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        op_i,
  input logic [ADDR_W-1:0] rs_addr_i,
  input logic [ADDR_W-1:0] rt_addr_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] rs_data_o,
  input logic [DATA_W-1:0] rt_data_o,
  input logic [DATA_W-1:0] result_o
);
  localparam int LOW_W = DATA_W - IMM_W;

  // shadow of the most recent non-zero write
  logic [ADDR_W-1:0] last_a_q;
  logic [DATA_W-1:0] last_d_q;
  logic              last_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_a_q <= '0;
      last_d_q <= '0;
      last_v_q <= 1'b0;
    end else if (wr_en_i && (rd_addr_i != '0)) begin
      last_a_q <= rd_addr_i;
      last_d_q <= result_o;
      last_v_q <= 1'b1;
    end
  end

  p_zero_rs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_addr_i == '0) |-> (rs_data_o == '0));
  p_zero_rt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_addr_i == '0) |-> (rt_data_o == '0));
  p_lui_shape_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd7) |-> (result_o == {imm_i, {LOW_W{1'b0}}}));
  p_slt_bool_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == 4'd3) || (op_i == 4'd4)) |-> (result_o[DATA_W-1:1] == '0));
  p_ori_upper_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd6) |-> (result_o[DATA_W-1:IMM_W] == rs_data_o[DATA_W-1:IMM_W]));
  p_spare_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i[3] |-> (result_o == '0));
  p_write_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_v_q && (rs_addr_i == last_a_q)) |-> (rs_data_o == last_d_q));
  p_add_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd0) |-> (result_o == DATA_W'(rs_data_o + rt_data_o)));
endmodule

bind rix_exec_top rix_exec_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_i      (op_i),
  .rs_addr_i (rs_addr_i),
  .rt_addr_i (rt_addr_i),
  .rd_addr_i (rd_addr_i),
  .imm_i     (imm_i),
  .wr_en_i   (wr_en_i),
  .rs_data_o (rs_data_o),
  .rt_data_o (rt_data_o),
  .result_o  (result_o)
);

// File: tb/rix_exec_top_bench.sv
module rix_exec_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [4:0]  rs = '0, rt = '0, rd = '0;
  logic [15:0] imm = '0;
  logic        we = 1'b0;
  logic [31:0] rs_d, rt_d, res;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit [31:0] model [32];

  always #4 clk = ~clk;

  rix_exec_top u_rix_exec_top (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .rs_addr_i(rs), .rt_addr_i(rt),
    .rd_addr_i(rd), .imm_i(imm), .wr_en_i(we),
    .rs_data_o(rs_d), .rt_data_o(rt_d), .result_o(res));

  function automatic bit [31:0] sx(bit [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic bit [31:0] expect_res(int code, bit [31:0] a, bit [31:0] b, bit [15:0] k);
    longint sa, sb;
    sa = longint'($signed(a));
    case (code)
      0: return a + b;
      1: return a - b;
      2: return a + sx(k);
      3: begin sb = longint'($signed(b)); return (sa < sb) ? 32'd1 : 32'd0; end
      4: begin sb = longint'($signed(sx(k))); return (sa < sb) ? 32'd1 : 32'd0; end
      5: return a & {16'h0, k};
      6: return a | {16'h0, k};
      7: return {k, 16'h0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one instruction: drive, compare outputs against model, then commit write
  task automatic issue(string tag, int code, int a, int b, int d, bit [15:0] k, bit w);
    bit [31:0] e;
    @(negedge clk);
    op = 4'(code); rs = 5'(a); rt = 5'(b); rd = 5'(d); imm = k; we = w;
    #1;
    e = expect_res(code, model[a], model[b], k);
    chk({tag, " rs"}, rs_d, model[a]);
    chk({tag, " rt"}, rt_d, model[b]);
    chk({tag, " res"}, res, e);
    @(posedge clk);
    if (w && d != 0) model[d] = e;
    #1 we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10: reset state
    for (int i = 0; i < 32; i += 2) issue("R10 reset", 0, i, i + 1, 0, 16'h0, 0);
    // R6/R7: build constants, same-register OR follows upper load
    issue("R6 lui", 7, 9, 0, 8, 16'hAAAA, 1);
    issue("R7 ori", 6, 8, 8, 8, 16'h5555, 1);
    chk("R7 const", model[8], 32'hAAAA5555);
    issue("R7 read", 0, 8, 0, 0, 16'h0, 0);
    issue("R6 lui", 7, 8, 0, 9, 16'h8000, 1);
    issue("R7 ori", 6, 9, 0, 9, 16'hFFFF, 1);
    issue("R7 lui", 7, 0, 0, 10, 16'h7FFF, 1);
    issue("R7 ori", 6, 10, 0, 10, 16'hFFFF, 1);
    // R1: wrap
    issue("R1 add wrap", 0, 10, 9, 11, 16'h0, 1);
    issue("R1 sub wrap", 1, 0, 8, 12, 16'h0, 1);
    issue("R1 sub", 1, 8, 10, 13, 16'h0, 1);
    // R2: sign-extended add
    issue("R2 addi neg", 2, 8, 0, 14, 16'hFFFF, 1);
    issue("R2 addi pos", 2, 0, 0, 15, 16'h7FFF, 1);
    issue("R2 addi min", 2, 15, 0, 16, 16'h8000, 1);
    // R3/R4: signed compares
    issue("R3 slt neg<pos", 3, 9, 10, 17, 16'h0, 1);
    issue("R3 slt pos<neg", 3, 10, 9, 18, 16'h0, 1);
    issue("R3 slt eq", 3, 8, 8, 19, 16'h0, 1);
    issue("R4 slti", 4, 14, 0, 20, 16'h0000, 1);
    issue("R4 slti neg", 4, 0, 0, 21, 16'hFFFE, 1);
    issue("R4 slti lt", 4, 14, 0, 22, 16'h0005, 1);
    // R5: zero-extended logic
    issue("R5 andi", 5, 9, 0, 23, 16'hF0F0, 1);
    issue("R5 ori", 6, 9, 0, 24, 16'h8001, 1);
    issue("R5 andi neg", 5, 14, 0, 25, 16'h8000, 1);
    // R8: entry zero ignores writes
    issue("R8 wr0", 7, 0, 0, 0, 16'h1234, 1);
    issue("R8 rd0", 0, 0, 0, 0, 16'h0, 0);
    // R9: no write with enable low, same-cycle read shows old value
    issue("R9 we0", 7, 0, 0, 8, 16'hDEAD, 0);
    issue("R9 hold", 0, 8, 0, 0, 16'h0, 0);
    issue("R9 same cyc", 2, 8, 8, 8, 16'h0001, 1);
    issue("R9 after", 0, 8, 8, 0, 16'h0, 0);
    // R11: spare codes
    for (int c = 8; c < 16; c++) issue("R11 spare", c, 8, 9, 26, 16'hFFFF, 1);
    // random mix
    for (int n = 0; n < 400; n++)
      issue("R1-mix", int'($urandom_range(0, 15)), int'($urandom_range(0, 31)),
            int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
            16'($urandom), 1'($urandom));
    // R10: reset clears written entries
    @(negedge clk); rst_n = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 32; i += 2) issue("R10 rereset", 0, i, i + 1, 0, 16'h0, 0);
    finish_run();
  end
endmodule